// File: doc/BRIEF.md
# Host Command Frame Validator

The block takes a host command frame one byte per accepted cycle, checks it, runs one of two built-in commands and streams back a response frame. A frame opens with a five-byte header: command code, flags, command version, payload length and checksum, in that order. The header is followed by as many payload bytes as the length field gives. The block keeps a running modulo-256 sum of the first four header bytes and of the payload, then compares it with the checksum byte. It also rejects lengths beyond the parameter area, checks the command version against a per-command mask, and computes a result code.

Two commands are built in. Code 0x01 is an echo that adds a constant to a 32-bit word. Code 0x00 returns the protocol version. Together they let the whole path be tested end to end. Bit 0 of the flags selects the exchange style. When it is set, the request is new-style: the checksum and the version are enforced and the reply carries the to-host flag. When it is clear, the request is old-style: the checksum is not enforced, the version is taken as 0 and the reply flags are zero. While the response streams out, the block reports itself busy and ignores input.

Top module: `hostcmd_frame_check`

## Requirements
- R1: Each frame is five header bytes (command, flags, version, length, checksum) followed by `length` payload bytes, with one byte accepted per cycle that has `in_valid` high. The response begins in the cycle after the last byte is accepted. It is laid out as result, reply flags, 0x00, reply length, reply checksum, then the reply payload, one byte per cycle, with `out_sof` on the first byte and `out_eof` on the last.
- R2: For a new-style request, the checksum is valid when it equals the 8-bit sum of command, flags, version, length and every payload byte. A mismatch yields result 7.
- R3: A length above 252 (0xFC) yields result 3 straight after the fifth header byte. No payload byte is consumed, so the next accepted byte is the command byte of a new frame.
- R4: A request with flags bit 0 clear is old-style. Its checksum is not checked, its version field is treated as 0, and its reply flags are 0x00.
- R5: A request with flags bit 0 set gets reply flags 0x02.
- R6: A command code other than 0x00 and 0x01 yields result 1.
- R7: Both commands support only version 0 (version mask 0x1). Any other effective version yields result 6.
- R8: Echo (0x01) with length 4 yields result 0, reply length 4, and a reply payload equal to the little-endian input word plus 0x01020304, least significant byte first.
- R9: Version query (0x00) with length 0 yields result 0, reply length 4, and reply payload 0x00000002 in little-endian order.
- R10: A known command whose length is not its required length (4 for echo, 0 for query) yields result 3.
- R11: A non-zero result sends reply length 0 and no payload, so the response is exactly five bytes.
- R12: The reply checksum is the 8-bit sum of result, reply flags, the zero version byte, reply length and every reply payload byte.
- R13: Checks are ranked in this order: oversize length, then checksum, then command, then version, then length. The first failing check sets the result.
- R14: After reset the block is idle, with `busy` and `out_valid` low. `busy` is high exactly while a response is streaming, and bytes offered during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request byte present |
| in_byte | input | 8 | Request byte |
| busy | output | 1 | Response in progress; input ignored |
| out_valid | output | 1 | Response byte present |
| out_byte | output | 8 | Response byte |
| out_sof | output | 1 | First byte of response |
| out_eof | output | 1 | Last byte of response |

## Verification
The hardest case to reach from the ports is an oversize length. The header ends early, so the next byte must be parsed as a fresh command. The stimulus therefore sends a length-253 header and follows it at once with a valid echo frame. The second hard case is input that arrives while a response is still streaming. To reach it, the bench drives random bytes on every busy cycle and then checks that the next frame is answered correctly. Random frames mix checksum corruption, odd versions, unknown codes and both styles, so the result ranking is exercised in many combinations.

// File: rtl/hostcmd_frame_check.sv
module hostcmd_frame_check #(
  parameter int unsigned MAX_LEN    = 252,
  parameter logic [31:0] ECHO_ADD   = 32'h0102_0304,
  parameter logic [31:0] PROTO_VER  = 32'h0000_0002,
  parameter logic [31:0] ECHO_VMASK = 32'h1,
  parameter logic [31:0] QRY_VMASK  = 32'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       busy,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_sof,
  output logic       out_eof
);
  localparam logic [7:0] CMD_QRY  = 8'h00;
  localparam logic [7:0] CMD_ECHO = 8'h01;
  localparam logic [7:0] FL_FROM  = 8'h01;
  localparam logic [7:0] FL_TO    = 8'h02;
  localparam logic [7:0] RES_OK   = 8'd0;
  localparam logic [7:0] RES_CMD  = 8'd1;
  localparam logic [7:0] RES_PAR  = 8'd3;
  localparam logic [7:0] RES_VER  = 8'd6;
  localparam logic [7:0] RES_SUM  = 8'd7;
  localparam logic [7:0] MAX_B    = 8'(MAX_LEN);

  typedef enum logic [1:0] {S_HDR, S_PAY, S_RSP} st_t;

  st_t        st;
  logic [7:0] cnt, cmd, flg, ver, len, csum, acc;
  logic [31:0] word;
  logic        big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HDR; cnt <= '0; cmd <= '0; flg <= '0; ver <= '0;
      len <= '0; csum <= '0; acc <= '0; word <= '0; big <= 1'b0;
    end else begin
      case (st)
        S_HDR: if (in_valid) begin
          case (cnt)
            8'd0: begin cmd <= in_byte; acc <= in_byte; word <= '0; end
            8'd1: begin flg <= in_byte; acc <= acc + in_byte; end
            8'd2: begin ver <= in_byte; acc <= acc + in_byte; end
            8'd3: begin len <= in_byte; acc <= acc + in_byte; end
            default: csum <= in_byte;
          endcase
          if (cnt == 8'd4) begin
            cnt <= '0;
            if (len > MAX_B) begin big <= 1'b1; st <= S_RSP; end
            else if (len == 8'd0) st <= S_RSP;
            else st <= S_PAY;
          end else cnt <= cnt + 8'd1;
        end
        S_PAY: if (in_valid) begin
          acc <= acc + in_byte;
          if (cnt < 8'd4) word[8*cnt[1:0] +: 8] <= in_byte;
          if (cnt == len - 8'd1) begin cnt <= '0; st <= S_RSP; end
          else cnt <= cnt + 8'd1;
        end
        default: begin
          if (out_eof) begin cnt <= '0; big <= 1'b0; st <= S_HDR; end
          else cnt <= cnt + 8'd1;
        end
      endcase
    end
  end

  logic        newsty, vok;
  logic [7:0]  ever, res, rflg, rlen, rsum;
  logic [31:0] rword, vmask;

  assign newsty = (flg & FL_FROM) != 8'h00;
  assign ever   = newsty ? ver : 8'h00;
  assign vmask  = (cmd == CMD_ECHO) ? ECHO_VMASK : QRY_VMASK;
  assign vok    = (ever < 8'd32) && vmask[ever[4:0]];

  always_comb begin
    if (big)                                  res = RES_PAR;
    else if (newsty && acc != csum)           res = RES_SUM;
    else if (cmd != CMD_QRY && cmd != CMD_ECHO) res = RES_CMD;
    else if (!vok)                            res = RES_VER;
    else if ((cmd == CMD_ECHO && len != 8'd4) ||
             (cmd == CMD_QRY && len != 8'd0)) res = RES_PAR;
    else                                      res = RES_OK;
  end

  assign rword = (cmd == CMD_ECHO) ? word + ECHO_ADD : PROTO_VER;
  assign rflg  = newsty ? FL_TO : 8'h00;
  assign rlen  = (res == RES_OK) ? 8'd4 : 8'd0;
  assign rsum  = res + rflg + rlen +
                 ((res == RES_OK) ? rword[7:0] + rword[15:8] + rword[23:16] + rword[31:24] : 8'h00);

  always_comb begin
    case (cnt)
      8'd0: out_byte = res;
      8'd1: out_byte = rflg;
      8'd2: out_byte = 8'h00;
      8'd3: out_byte = rlen;
      8'd4: out_byte = rsum;
      8'd5: out_byte = rword[7:0];
      8'd6: out_byte = rword[15:8];
      8'd7: out_byte = rword[23:16];
      default: out_byte = rword[31:24];
    endcase
  end

  assign busy      = (st == S_RSP);
  assign out_valid = busy;
  assign out_sof   = busy && cnt == 8'd0;
  assign out_eof   = busy && cnt == 8'd4 + rlen;
endmodule

module hostcmd_frame_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_sof,
  input logic       out_eof
);
  // R1
  eof_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) out_eof |-> out_valid);
  // R1
  frame_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |=> (out_valid && !out_sof));
  // R14
  idle_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n) out_eof |=> !busy);
  // R1
  sof_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> out_sof);
  // R13
  res_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_byte == 8'd0 || out_byte == 8'd1 || out_byte == 8'd3 ||
                 out_byte == 8'd6 || out_byte == 8'd7));
  // R11
  err_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && out_byte != 8'd0) |-> ##4 out_eof);
  // R8
  ok_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && out_byte == 8'd0) |-> ##8 out_eof);
endmodule

bind hostcmd_frame_check hostcmd_frame_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_byte(out_byte), .out_sof(out_sof), .out_eof(out_eof));

// File: tb/test_hostcmd_frame_check.sv
`timescale 1ns/1ps
module test_hostcmd_frame_check;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic busy, out_valid, out_sof, out_eof;
  logic [7:0] out_byte;
  int n_chk = 0, n_fail = 0;
  bit finished = 0, jam = 0;
  logic [7:0] cap [0:15];
  int ncap = 0;
  logic [7:0] ex [0:8];
  int exn;

  always #2.5 clk = ~clk;

  hostcmd_frame_check i_hostcmd_frame_check (.*);

  always @(negedge clk) if (out_valid && ncap < 16) begin cap[ncap] = out_byte; ncap++; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic logic [7:0] pbyte(input int i, input logic [31:0] w);
    return (i < 4) ? w[8*i +: 8] : 8'(i * 37 + 5);
  endfunction

  task automatic expect_frame(input logic [7:0] cmd, flg, ver, sz, cs, sum, input logic [31:0] w);
    logic [7:0] res, rf; logic [31:0] rw; bit nw;
    nw = flg[0];
    if (sz > 8'd252) res = 3;
    else if (nw && cs != sum) res = 7;
    else if (cmd != 8'h00 && cmd != 8'h01) res = 1;
    else if ((nw ? ver : 8'h00) != 8'h00) res = 6;
    else if ((cmd == 8'h01 && sz != 4) || (cmd == 8'h00 && sz != 0)) res = 3;
    else res = 0;
    rf = nw ? 8'h02 : 8'h00;
    rw = (cmd == 8'h01) ? w + 32'h0102_0304 : 32'h2;
    ex[0] = res; ex[1] = rf; ex[2] = 0; ex[3] = (res == 0) ? 8'd4 : 8'd0;
    ex[4] = ex[0] + ex[1] + ex[3];
    exn = 5;
    if (res == 0) begin
      for (int i = 0; i < 4; i++) begin ex[5+i] = rw[8*i +: 8]; ex[4] = ex[4] + rw[8*i +: 8]; end
      exn = 9;
    end
  endtask

  task automatic send(input string tag, input logic [7:0] cmd, flg, ver, sz,
                      input logic [31:0] w, input bit bad);
    logic [7:0] sum, cs; int np;
    sum = cmd + flg + ver + sz;
    np = (sz > 8'd252) ? 0 : int'(sz);
    for (int i = 0; i < np; i++) sum = sum + pbyte(i, w);
    cs = bad ? (sum ^ 8'h5A) : sum;
    expect_frame(cmd, flg, ver, sz, cs, sum, w);
    ncap = 0;
    for (int i = 0; i < 5 + np; i++) begin
      @(negedge clk); in_valid = 1'b1;
      in_byte = (i == 0) ? cmd : (i == 1) ? flg : (i == 2) ? ver : (i == 3) ? sz :
                (i == 4) ? cs : pbyte(i - 5, w);
    end
    @(negedge clk); in_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      in_valid = jam && busy; in_byte = 8'($urandom);
    end
    in_valid = 1'b0;
    check(ncap == exn, {tag, " R1 length"}, ncap, exn);
    for (int i = 0; i < exn && i < ncap; i++)
      check(cap[i] == ex[i], $sformatf("%s byte%0d", tag, i), cap[i], ex[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid, "R14 reset idle", {busy, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send("R8 R5 R12 echo", 8'h01, 8'h01, 0, 4, 32'h11FF_80F0, 0);
    send("R8 carry", 8'h01, 8'h01, 0, 4, 32'hFEFD_FCFC, 0);
    send("R9 query", 8'h00, 8'h01, 0, 0, 0, 0);
    send("R2 bad checksum", 8'h01, 8'h01, 0, 4, 32'h1234, 1);
    send("R4 old style", 8'h01, 8'h00, 3, 4, 32'hA5A5, 1);
    send("R6 unknown", 8'h55, 8'h01, 0, 0, 0, 0);
    send("R7 version", 8'h01, 8'h01, 1, 4, 0, 0);
    send("R10 R11 echo size", 8'h01, 8'h01, 0, 3, 0, 0);
    send("R10 max payload", 8'h00, 8'h01, 0, 252, 32'h77, 0);
    send("R3 oversize", 8'h01, 8'h01, 0, 253, 0, 0);
    send("R3 next frame", 8'h01, 8'h01, 0, 4, 32'h0BAD_F00D, 0);
    send("R3 oversize bad sum", 8'h01, 8'h01, 0, 255, 0, 1);
    send("R13 sum over cmd", 8'h55, 8'h01, 0, 0, 0, 1);
    send("R13 cmd over ver", 8'h55, 8'h01, 2, 4, 0, 0);
    send("R13 ver over len", 8'h01, 8'h03, 2, 7, 0, 0);
    jam = 1;
    send("R14 jam", 8'h00, 8'h01, 0, 0, 0, 0);
    jam = 0;
    send("R14 after jam", 8'h01, 8'h01, 0, 4, 32'h2468_ACE0, 0);
    void'($urandom(32'd77));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] c, f, v, s; int r;
      r = int'($urandom_range(0, 9));
      c = (r < 4) ? 8'h01 : (r < 7) ? 8'h00 : 8'($urandom);
      f = 8'($urandom_range(0, 3));
      v = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(1, 4)) : 8'h00;
      r = int'($urandom_range(0, 9));
      s = (r < 4) ? 8'd4 : (r < 6) ? 8'd0 : (r < 8) ? 8'($urandom_range(1, 12)) : 8'($urandom_range(250, 255));
      send("R13 random", c, f, v, s, $urandom, $urandom_range(0, 4) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R14 watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule